// File: doc/BRIEF.md
# Serial Wire Debug Host Packet Engine

This block is the host end of a two-wire debug link. It turns one access request into a full serial packet on a clock output and a shared data line. The request gives the direction, a two-bit register address, a port select and write data. The data line is split at the block edge into an output value, an output enable and an input, and a pad outside the block combines them. The block divides the system clock to make the serial clock. The serial clock stays low between packets, and while the host owns the line it rests high.

A packet runs in this order. An eight-bit header goes out first. The host then releases the line for one bit-time, and the target returns a three-bit response. What happens next depends on that response. On a good read, 32 data bits and a parity bit are received, followed by one released bit. On a good write, one released bit is followed by 32 data bits and a parity bit driven by the host. On any other response, one released bit ends the packet. When the packet ends, the block reports the response code, the read data and a read parity error, and it raises a one-cycle completion pulse.

Top module: `swd_host_engine`

## Requirements
- R1: After reset and between packets, swclk_o is 0, swdio_oe_o is 1, swdio_o is 1, busy_o is 0 and done_o is 0.
- R2: During a packet, each serial bit lasts 2*HALF_DIV system cycles. swclk_o is low for the first HALF_DIV cycles of the bit and high for the rest.
- R3: swdio_o and swdio_oe_o change only on the system-clock edge where swclk_o falls, so a driven value is steady for a whole bit.
- R4: The header is driven in this bit order: 1, req_ap_i, req_rnw_i, req_addr_i[0], req_addr_i[1], then the even parity (XOR) of those four bits, then 0, then 1.
- R5: For the one bit that follows the header, swdio_oe_o is 0.
- R6: The response is received over three bits with swdio_oe_o at 0, least significant bit first. Each bit is sampled in the last system cycle before swclk_o rises. The three bits are reported on ack_o. Code 3'b001 means OK, 3'b010 means WAIT and 3'b100 means FAULT.
- R7: On a read with an OK response, 33 bits are received least significant bit first: 32 data bits, then a parity bit. One released bit follows, and the data then appears on rdata_o.
- R8: After a good read, perr_o is 1 exactly when the received parity bit differs from the XOR of the 32 received data bits.
- R9: On a write with an OK response, one released bit is followed by req_wdata_i driven least significant bit first, then its XOR parity. swdio_oe_o is 1 for those 33 bits.
- R10: Any response other than 3'b001 skips the data phase. The packet ends after one released bit, with rdata_o at 0 and perr_o at 0.
- R11: A request is taken when req_valid_i is 1 and busy_o is 0. busy_o stays 1 from the next cycle until the packet ends. done_o is a one-cycle pulse in the first idle cycle, with the results valid from that cycle on. Requests made while busy_o is 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| req_rnw_i | input | 1 | 1 = read, 0 = write |
| req_ap_i | input | 1 | 1 = access port, 0 = debug port |
| req_addr_i | input | 2 | Register address bits 3:2 |
| req_wdata_i | input | 32 | Write data |
| busy_o | output | 1 | Packet in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ack_o | output | 3 | Received response code |
| rdata_o | output | 32 | Received read data |
| perr_o | output | 1 | Read parity mismatch |
| swclk_o | output | 1 | Serial clock |
| swdio_o | output | 1 | Data line output value |
| swdio_oe_o | output | 1 | Data line output enable |
| swdio_i | input | 1 | Data line input |

## Verification
The bench builds the engine with HALF_DIV=2 and DATA_W=32. A bit-time is then four system cycles, so the low and high halves of each bit each last more than one cycle. This lets the bench see a change in the middle of a half, and a sample taken on the wrong edge of the half. Because packets are short, one run can cover every response code, including one that is not defined. It also covers reads with correct and corrupted parity, writes of edge-case data, requests held high while the engine is busy, and packets started back to back.

// File: rtl/swd_pkg.sv
`timescale 1ns/1ps
package swd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_TRN_A,
    ST_ACK,
    ST_RD,
    ST_TRN_W,
    ST_WR,
    ST_TRN_E
  } seq_state_e;

  localparam int          HDR_BITS = 8;
  localparam int          ACK_BITS = 3;
  localparam logic [2:0]  RESP_OK    = 3'b001;
  localparam logic [2:0]  RESP_WAIT  = 3'b010;
  localparam logic [2:0]  RESP_FAULT = 3'b100;
endpackage

// File: rtl/swd_clkgen.sv
`timescale 1ns/1ps
// Serial clock divider: counts half periods, emits rise and fall events.
module swd_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ph_q, ph_d;
  logic          term;

  assign term = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (!run_i) begin
      cnt_d = '0;
      ph_d  = 1'b0;
    end else if (term) begin
      cnt_d = '0;
      ph_d  = ~ph_q;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign sclk_o = ph_q;
  assign rise_o = run_i & term & ~ph_q;
  assign fall_o = run_i & term &  ph_q;

  // R1: clock parked low whenever the engine is not running
  a_r1_clk_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !sclk_o);

  // R2: level holds inside a half period
  a_r2_half_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !term) |=> $stable(sclk_o));
endmodule

// File: rtl/swd_tx.sv
`timescale 1ns/1ps
// Outgoing shift register shared by the header and the write data phase.
module swd_tx #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_hdr_i,
  input  logic [7:0]        hdr_i,
  input  logic              load_dat_i,
  input  logic [DATA_W-1:0] dat_i,
  input  logic              shift_i,
  output logic              bit_o
);
  localparam int SW = DATA_W + 1;

  logic [SW-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load_hdr_i) begin
      sr_d = {{(SW-8){1'b1}}, hdr_i};
    end else if (load_dat_i) begin
      sr_d = {^dat_i, dat_i};
    end else if (shift_i) begin
      sr_d = {1'b1, sr_q[SW-1:1]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '1;
    end else begin
      sr_q <= sr_d;
    end
  end

  assign bit_o = sr_q[0];

  // R9: a data load never coincides with a header load
  a_r9_single_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_hdr_i && load_dat_i));
endmodule

// File: rtl/swd_rx.sv
`timescale 1ns/1ps
// Incoming shift registers for response and read data, plus result registers.
module swd_rx #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              samp_ack_i,
  input  logic              samp_dat_i,
  input  logic              din_i,
  input  logic              capture_i,
  input  logic              keep_dat_i,
  output logic [2:0]        ack_raw_o,
  output logic [2:0]        ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              perr_o
);
  logic [2:0]        ack_sr_q, ack_sr_d;
  logic [DATA_W:0]   dat_sr_q, dat_sr_d;
  logic [2:0]        ack_q, ack_d;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              pe_q, pe_d;

  always_comb begin
    ack_sr_d = ack_sr_q;
    dat_sr_d = dat_sr_q;
    ack_d    = ack_q;
    rd_d     = rd_q;
    pe_d     = pe_q;
    if (clear_i) begin
      ack_sr_d = '0;
      dat_sr_d = '0;
      ack_d    = '0;
      rd_d     = '0;
      pe_d     = 1'b0;
    end else begin
      if (samp_ack_i) ack_sr_d = {din_i, ack_sr_q[2:1]};
      if (samp_dat_i) dat_sr_d = {din_i, dat_sr_q[DATA_W:1]};
      if (capture_i) begin
        ack_d = ack_sr_q;
        if (keep_dat_i) begin
          rd_d = dat_sr_q[DATA_W-1:0];
          pe_d = ^dat_sr_q;
        end else begin
          rd_d = '0;
          pe_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_sr_q <= '0;
      dat_sr_q <= '0;
      ack_q    <= '0;
      rd_q     <= '0;
      pe_q     <= 1'b0;
    end else begin
      ack_sr_q <= ack_sr_d;
      dat_sr_q <= dat_sr_d;
      ack_q    <= ack_d;
      rd_q     <= rd_d;
      pe_q     <= pe_d;
    end
  end

  assign ack_raw_o = ack_sr_q;
  assign ack_o     = ack_q;
  assign rdata_o   = rd_q;
  assign perr_o    = pe_q;

  // R6: response and data are never shifted in the same cycle
  a_r6_one_sampler: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(samp_ack_i && samp_dat_i));
endmodule

// File: rtl/swd_host_engine.sv
`timescale 1ns/1ps
module swd_host_engine #(
  parameter int HALF_DIV = 2,
  parameter int DATA_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_rnw_i,
  input  logic              req_ap_i,
  input  logic [1:0]        req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [2:0]        ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              perr_o,
  output logic              swclk_o,
  output logic              swdio_o,
  output logic              swdio_oe_o,
  input  logic              swdio_i
);
  import swd_pkg::*;

  localparam int BW = $clog2(DATA_W + 1) + 1;
  localparam logic [BW-1:0] HDR_LAST = BW'(HDR_BITS - 1);
  localparam logic [BW-1:0] ACK_LAST = BW'(ACK_BITS - 1);
  localparam logic [BW-1:0] DAT_LAST = BW'(DATA_W);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  seq_state_e        state_q, state_d;
  logic [BW-1:0]     bcnt_q, bcnt_d;
  logic              rnw_q, rnw_d;
  logic [DATA_W-1:0] wdat_q, wdat_d;
  logic              done_q, done_d;

  logic       accept;
  logic       fall_w, rise_w;
  logic       load_hdr, load_dat, tx_shift, tx_bit;
  logic       finish, keep_dat;
  logic       samp_ack, samp_dat;
  logic [2:0] ack_raw;
  logic [7:0] hdr;

  assign accept = req_valid_i && (state_q == ST_IDLE);

  // header, bit 0 first on the wire
  assign hdr = {1'b1, 1'b0,
                req_ap_i ^ req_rnw_i ^ req_addr_i[0] ^ req_addr_i[1],
                req_addr_i[1], req_addr_i[0], req_rnw_i, req_ap_i, 1'b1};

  swd_clkgen #(.HALF_DIV(HALF_DIV)) i_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .run_i  (state_q != ST_IDLE),
    .sclk_o (swclk_o),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  swd_tx #(.DATA_W(DATA_W)) i_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .load_hdr_i (load_hdr),
    .hdr_i      (hdr),
    .load_dat_i (load_dat),
    .dat_i      (wdat_q),
    .shift_i    (tx_shift),
    .bit_o      (tx_bit)
  );

  assign samp_ack = rise_w && (state_q == ST_ACK);
  assign samp_dat = rise_w && (state_q == ST_RD);
  assign keep_dat = rnw_q && (ack_raw == RESP_OK);

  swd_rx #(.DATA_W(DATA_W)) i_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .clear_i    (accept),
    .samp_ack_i (samp_ack),
    .samp_dat_i (samp_dat),
    .din_i      (swdio_i),
    .capture_i  (finish),
    .keep_dat_i (keep_dat),
    .ack_raw_o  (ack_raw),
    .ack_o      (ack_o),
    .rdata_o    (rdata_o),
    .perr_o     (perr_o)
  );

  // next-state logic; bit boundaries are the serial clock falls
  always_comb begin
    state_d  = state_q;
    bcnt_d   = bcnt_q;
    rnw_d    = rnw_q;
    wdat_d   = wdat_q;
    load_hdr = 1'b0;
    load_dat = 1'b0;
    tx_shift = 1'b0;
    finish   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          state_d  = ST_HDR;
          bcnt_d   = '0;
          rnw_d    = req_rnw_i;
          wdat_d   = req_wdata_i;
          load_hdr = 1'b1;
        end
      end
      ST_HDR: begin
        if (fall_w) begin
          if (bcnt_q == HDR_LAST) begin
            state_d = ST_TRN_A;
            bcnt_d  = '0;
          end else begin
            bcnt_d   = bcnt_q + BW'(1);
            tx_shift = 1'b1;
          end
        end
      end
      ST_TRN_A: begin
        if (fall_w) begin
          state_d = ST_ACK;
          bcnt_d  = '0;
        end
      end
      ST_ACK: begin
        if (fall_w) begin
          if (bcnt_q == ACK_LAST) begin
            bcnt_d = '0;
            if (ack_raw != RESP_OK) state_d = ST_TRN_E;
            else if (rnw_q)         state_d = ST_RD;
            else                    state_d = ST_TRN_W;
          end else begin
            bcnt_d = bcnt_q + BW'(1);
          end
        end
      end
      ST_RD: begin
        if (fall_w) begin
          if (bcnt_q == DAT_LAST) begin
            state_d = ST_TRN_E;
            bcnt_d  = '0;
          end else begin
            bcnt_d = bcnt_q + BW'(1);
          end
        end
      end
      ST_TRN_W: begin
        if (fall_w) begin
          state_d  = ST_WR;
          bcnt_d   = '0;
          load_dat = 1'b1;
        end
      end
      ST_WR: begin
        if (fall_w) begin
          if (bcnt_q == DAT_LAST) begin
            state_d = ST_IDLE;
            bcnt_d  = '0;
            finish  = 1'b1;
          end else begin
            bcnt_d   = bcnt_q + BW'(1);
            tx_shift = 1'b1;
          end
        end
      end
      ST_TRN_E: begin
        if (fall_w) begin
          state_d = ST_IDLE;
          bcnt_d  = '0;
          finish  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    done_d = finish;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bcnt_q  <= '0;
      rnw_q   <= 1'b0;
      wdat_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bcnt_q  <= bcnt_d;
      done_q  <= done_d;
      if (accept) begin
        rnw_q  <= rnw_d;
        wdat_q <= wdat_d;
      end
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign swdio_oe_o = (state_q == ST_IDLE) || (state_q == ST_HDR) || (state_q == ST_WR);
  assign swdio_o    = ((state_q == ST_HDR) || (state_q == ST_WR)) ? tx_bit : 1'b1;

  // R3: line value and ownership move only at a serial clock fall
  a_r3_change_on_fall: assert property (@(posedge clk_i) disable iff (!rst_n)
    !($stable(swdio_o) && $stable(swdio_oe_o)) |-> $past(fall_w));

  // R6: target bits are only taken while the host has let go of the line
  a_r6_sample_released: assert property (@(posedge clk_i) disable iff (!rst_n)
    (samp_ack || samp_dat) |-> !swdio_oe_o);

  // R11: busy only starts from a presented request
  a_r11_start_needs_req: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(busy_o) |-> $past(req_valid_i));

  // R11: completion is a single-cycle pulse seen while idle
  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |-> (!busy_o ##1 !done_o));

  // R10: a failed response leaves no read result behind
  a_r10_no_data_on_fail: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_o && ack_o != RESP_OK) |-> (rdata_o == '0 && !perr_o));
endmodule

// File: tb/test_swd_host_engine.sv
`timescale 1ns/1ps
module test_swd_host_engine;
  localparam int H = 2;
  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic          req_valid, req_rnw, req_ap;
  logic [1:0]    req_addr;
  logic [DW-1:0] req_wdata;
  logic          busy, done, perr, swclk, swdio, swdio_oe, swdio_in;
  logic [2:0]    ack;
  logic [DW-1:0] rdata;

  swd_host_engine #(.HALF_DIV(H), .DATA_W(DW)) i_swd_host_engine (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .req_rnw_i   (req_rnw),
    .req_ap_i    (req_ap),
    .req_addr_i  (req_addr),
    .req_wdata_i (req_wdata),
    .busy_o      (busy),
    .done_o      (done),
    .ack_o       (ack),
    .rdata_o     (rdata),
    .perr_o      (perr),
    .swclk_o     (swclk),
    .swdio_o     (swdio),
    .swdio_oe_o  (swdio_oe),
    .swdio_i     (swdio_in)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    bit            clk;
    bit            oe;
    bit            dout;
    bit            busy;
    bit            done;
    bit            tgt;
    bit            res;
    logic [2:0]    ack;
    logic [DW-1:0] rd;
    bit            pe;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   mon_on = 1'b0;
  bit   finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic exp_t mk(bit c, bit oe, bit d, bit b, bit t, string tag);
    exp_t e;
    e.clk = c; e.oe = oe; e.dout = d; e.busy = b; e.done = 1'b0; e.tgt = t;
    e.res = 1'b0; e.ack = '0; e.rd = '0; e.pe = 1'b0; e.tag = tag;
    return e;
  endfunction

  // one serial bit: low half, then high half (R2)
  task automatic push_slot(bit oe, bit d, bit t, string tag);
    for (int i = 0; i < H; i++) q.push_back(mk(1'b0, oe, d, 1'b1, t, tag));
    for (int i = 0; i < H; i++) q.push_back(mk(1'b1, oe, d, 1'b1, t, tag));
  endtask

  // per-cycle comparison against the reference stream
  initial begin
    swdio_in = 1'b1;
    forever begin
      @(negedge clk);
      if (mon_on) begin
        exp_t e;
        if (q.size() > 0) e = q.pop_front();
        else e = mk(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R1");
        swdio_in = e.tgt;
        chk(swclk == e.clk, (e.tag == "R1") ? "R1" : "R2", "swclk", DW'(swclk), DW'(e.clk));
        chk(swdio_oe == e.oe, e.tag, "swdio_oe", DW'(swdio_oe), DW'(e.oe));
        if (e.oe) chk(swdio == e.dout, e.tag, "swdio", DW'(swdio), DW'(e.dout));
        chk(busy == e.busy, "R11", "busy", DW'(busy), DW'(e.busy));
        chk(done == e.done, "R11", "done", DW'(done), DW'(e.done));
        if (e.res) begin
          chk(ack == e.ack, "R6", "ack", DW'(ack), DW'(e.ack));
          chk(rdata == e.rd, "R7", "rdata", rdata, e.rd);
          chk(perr == e.pe, "R8", "perr", DW'(perr), DW'(e.pe));
        end
      end
    end
  end

  task automatic run_pkt(bit rnw, bit ap, logic [1:0] addr, logic [DW-1:0] wd,
                         logic [2:0] tack, logic [DW-1:0] trd, bit bad_par, bit spam);
    bit   ok;
    bit   hb[8];
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_rnw = rnw; req_ap = ap; req_addr = addr; req_wdata = wd;
    @(posedge clk);
    ok = (tack == 3'b001);
    hb[0] = 1'b1; hb[1] = ap; hb[2] = rnw; hb[3] = addr[0]; hb[4] = addr[1];
    hb[5] = ap ^ rnw ^ addr[0] ^ addr[1]; hb[6] = 1'b0; hb[7] = 1'b1;
    for (int i = 0; i < 8; i++) push_slot(1'b1, hb[i], 1'b1, "R4 R3");
    push_slot(1'b0, 1'b1, 1'b0, "R5");
    for (int i = 0; i < 3; i++) push_slot(1'b0, 1'b1, tack[i], "R6");
    if (ok && rnw) begin
      for (int i = 0; i < DW; i++) push_slot(1'b0, 1'b1, trd[i], "R7");
      push_slot(1'b0, 1'b1, (^trd) ^ bad_par, "R8");
      push_slot(1'b0, 1'b1, 1'b0, "R7");
    end else if (ok) begin
      push_slot(1'b0, 1'b1, 1'b0, "R9");
      for (int i = 0; i < DW; i++) push_slot(1'b1, wd[i], 1'b0, "R9 R3");
      push_slot(1'b1, ^wd, 1'b0, "R9");
    end else begin
      push_slot(1'b0, 1'b1, 1'b0, "R10");
    end
    e = mk(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R11");
    e.done = 1'b1; e.res = 1'b1; e.ack = tack;
    e.rd = (ok && rnw) ? trd : '0;
    e.pe = ok && rnw && bad_par;
    q.push_back(e);
    @(negedge clk);
    if (spam) begin
      // R11: requests with other fields while busy must leave the stream unchanged
      req_rnw = ~rnw; req_ap = ~ap; req_addr = ~addr; req_wdata = ~wd;
      while (q.size() > 4) @(negedge clk);
    end
    req_valid = 1'b0;
    while (q.size() > 0) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++;
        checks++;
        $display("FAIL R11 watchdog: actual %0d expected <= 20000 cycles", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_rnw = 1'b0; req_ap = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mon_on = 1'b1;
    repeat (4) @(negedge clk);                                       // R1 idle state
    run_pkt(1'b1, 1'b1, 2'b10, 32'h0, 3'b001, 32'hA5C3_0F12, 1'b0, 1'b0);  // R7 good read
    run_pkt(1'b0, 1'b0, 2'b01, 32'h8000_0001, 3'b001, 32'h0, 1'b0, 1'b0);  // R9 write
    run_pkt(1'b1, 1'b0, 2'b00, 32'h0, 3'b010, 32'hFFFF_FFFF, 1'b0, 1'b0);  // R10 wait
    run_pkt(1'b0, 1'b1, 2'b11, 32'h1234_5678, 3'b100, 32'h0, 1'b0, 1'b0);  // R10 fault
    run_pkt(1'b1, 1'b1, 2'b01, 32'h0, 3'b001, 32'h0F0F_1234, 1'b1, 1'b0);  // R8 bad parity
    run_pkt(1'b1, 1'b0, 2'b11, 32'h0, 3'b001, 32'h0000_0000, 1'b0, 1'b1);  // R11 spam while busy
    run_pkt(1'b1, 1'b1, 2'b10, 32'h0, 3'b111, 32'hDEAD_BEEF, 1'b0, 1'b0);  // R10 undefined code
    run_pkt(1'b0, 1'b1, 2'b11, 32'hFFFF_FFFF, 3'b001, 32'h0, 1'b0, 1'b1);  // R9 all ones, spam
    run_pkt(1'b1, 1'b0, 2'b01, 32'h0, 3'b001, 32'h7FFF_FFFE, 1'b1, 1'b0);  // R8 second parity case
    repeat (8) @(negedge clk);                                       // R1 rest after packets
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule